// File: doc/BRIEF.md
# Genlock Reference Nibble Inserter

This block sits on the composite video output path. It forwards an 8-bit pixel stream and, once per line, replaces it with a short genlock reference packet placed inside the horizontal sync tip. The packet is 13 nibbles long. It carries a field identifier, then a 24-bit subcarrier frequency word, then a 24-bit subcarrier phase word. The nibbles are driven on the low four bits of the bus, one per fast clock, and the upper four bits are held at zero. A downstream encoder or frame store reads the packet to recover field sequence and subcarrier state.

The packet begins a parameterised number of clocks after the sync-tip strobe rises. The frequency and phase words, together with the field state, are captured when the packet begins, so one packet never mixes old and new values. A disable control suppresses the packet and lets pixels through. When the line lock is lost, a separate control blanks all pixel data but still lets the packet out.

Top module: `grs_nibble_mux`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe edge, no packet is active and the bus equals `pix_in` (given that forced blanking is not active).
- R2: The first nibble appears on the bus START_DLY clock edges after the first rising clock edge that samples `tip_win` high following a low sample. Before that edge, the bus still carries idle data.
- R3: The packet has 13 nibbles, one per clock. The order is: field nibble, frequency bits 23:20 down to 3:0, phase bits 23:20 down to 3:0. On the clock after the last nibble, the bus returns to idle data.
- R4: While a nibble is on the bus, bus bits 7:4 are zero.
- R5: With `pal_mode` low, the field nibble bits 1:0 equal `fld_cnt[1:0]`, and bit 2 is zero. `fld_cnt` is zero-based: field 1 = 0. Bit 0 is therefore high in even fields.
- R6: With `pal_mode` high, the field nibble bits 2:0 equal `fld_cnt[2:0]`, giving 000 to 111 over fields 1 to 8.
- R7: Field nibble bit 3 is 1 when `pal_mode` is low. When `pal_mode` is high, bit 3 is the inverse of `v_inv` (low on V-inverted lines).
- R8: The frequency word, the phase word and the field state are sampled on the clock edge where the packet begins. Later changes to these inputs do not alter that packet.
- R9: While `pkt_off` is high, no nibble reaches the bus, and idle data passes through for the whole sync-tip window.
- R10: When `locked` is low and `blank_unlk` is high, the bus is 0x00 except while nibbles are sent. The packet itself is still sent. With `locked` high, `blank_unlk` has no effect.
- R11: A new rising edge of `tip_win` is ignored while a packet is pending or being sent. It neither restarts nor extends the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (twice the pixel rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 8 | Composite pixel data |
| tip_win | input | 1 | Sync-tip window strobe, high during the tip |
| fld_cnt | input | 3 | Zero-based field sequence count |
| pal_mode | input | 1 | Format select: 1 = PAL, 0 = NTSC |
| v_inv | input | 1 | Current PAL line has V inverted |
| sc_freq | input | 24 | Subcarrier frequency word |
| sc_phase | input | 24 | Subcarrier phase word |
| pkt_off | input | 1 | Suppress the packet |
| blank_unlk | input | 1 | Blank pixel data while unlocked |
| locked | input | 1 | Line lock flag |
| bus_out | output | 8 | Multiplexed output bus |

## Verification
The bench builds the block with START_DLY = 3. With that value the idle clocks before the first nibble can be counted and checked one by one. A second strobe edge can also be placed while the packet is running. The table vectors cover both formats, both values of the inversion flag, and field counts whose upper bit must be dropped in NTSC. Directed runs move the words in the middle of a packet, toggle the strobe inside a packet, and combine lock loss with forced blanking and with the disable control.

// File: rtl/grs_nibble_mux.sv
module grs_nibble_mux #(
  parameter int START_DLY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pix_in,
  input  logic        tip_win,
  input  logic [2:0]  fld_cnt,
  input  logic        pal_mode,
  input  logic        v_inv,
  input  logic [23:0] sc_freq,
  input  logic [23:0] sc_phase,
  input  logic        pkt_off,
  input  logic        blank_unlk,
  input  logic        locked,
  output logic [7:0]  bus_out
);
  localparam int NIBS = 13;
  localparam int DW   = $clog2(START_DLY) + 1;
  localparam int PW   = 4 * NIBS;

  logic          tip_q, arm, act;
  logic [DW-1:0] dly;
  logic [3:0]    idx;
  logic [PW-1:0] sh;
  logic [3:0]    fld_nib;
  logic          tip_rise, send, force_lo;

  assign tip_rise = tip_win & ~tip_q;
  assign fld_nib  = {pal_mode ? ~v_inv : 1'b1, pal_mode & fld_cnt[2], fld_cnt[1:0]};
  assign send     = act & ~pkt_off;
  assign force_lo = ~locked & blank_unlk;
  assign bus_out  = send ? {4'h0, sh[PW-1 -: 4]} : (force_lo ? 8'h00 : pix_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tip_q <= 1'b0;
      arm   <= 1'b0;
      act   <= 1'b0;
      dly   <= '0;
      idx   <= '0;
      sh    <= '0;
    end else begin
      tip_q <= tip_win;
      if (act) begin
        sh <= {sh[PW-5:0], 4'h0};
        if (idx == 4'(NIBS - 1)) act <= 1'b0;
        else                     idx <= idx + 4'd1;
      end else if (arm) begin
        if (dly == '0) begin
          arm <= 1'b0;
          act <= 1'b1;
          idx <= '0;
          sh  <= {fld_nib, sc_freq, sc_phase};
        end else begin
          dly <= dly - 1'b1;
        end
      end else if (tip_rise) begin
        arm <= 1'b1;
        dly <= DW'(START_DLY - 1);
      end
    end
  end

  AST_NIB_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    send |-> bus_out[7:4] == 4'h0); // R4
  AST_PKT_END: assert property (@(posedge clk) disable iff (!rst_n)
    act && idx == 4'(NIBS - 1) |=> !act); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    act && idx != 4'(NIBS - 1) |=> act && idx == $past(idx) + 4'd1); // R3
  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    arm && dly == '0 |=> act && idx == 4'd0); // R2
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    arm && dly != '0 |=> arm && dly == $past(dly) - 1'b1); // R11
  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm && act)); // R11
  AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    force_lo && !send |-> bus_out == 8'h00); // R10
endmodule

// File: tb/test_grs_nibble_mux.sv
module test_grs_nibble_mux;
  localparam int S = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pix_in = 8'hA5;
  logic        tip_win = 1'b0;
  logic [2:0]  fld_cnt = 3'd0;
  logic        pal_mode = 1'b0;
  logic        v_inv = 1'b0;
  logic [23:0] sc_freq = 24'h0;
  logic [23:0] sc_phase = 24'h0;
  logic        pkt_off = 1'b0;
  logic        blank_unlk = 1'b0;
  logic        locked = 1'b1;
  logic [7:0]  bus_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  grs_nibble_mux #(.START_DLY(S)) i_grs_nibble_mux (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .tip_win(tip_win),
    .fld_cnt(fld_cnt), .pal_mode(pal_mode), .v_inv(v_inv),
    .sc_freq(sc_freq), .sc_phase(sc_phase), .pkt_off(pkt_off),
    .blank_unlk(blank_unlk), .locked(locked), .bus_out(bus_out));

  // {pal, v_inv, fld[2:0], freq[23:0], phase[23:0], expected field nibble}
  localparam logic [56:0] VEC [4] = '{
    {1'b0, 1'b0, 3'd0, 24'h123456, 24'h9ABCDE, 4'h8},
    {1'b0, 1'b1, 3'd7, 24'hFEDCBA, 24'h013579, 4'hB},
    {1'b1, 1'b1, 3'd5, 24'h5A5A5A, 24'hC3C3C3, 4'h5},
    {1'b1, 1'b0, 3'd6, 24'h0F1E2D, 24'h3C4B5A, 4'hE}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: bus_out=%h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] idle_val();
    return (!locked && blank_unlk) ? 8'h00 : pix_in;
  endfunction

  task automatic run_pkt(input logic [56:0] v, input bit mid_change, input bit retrig);
    logic [47:0] w;
    logic [7:0]  e;
    pal_mode = v[56]; v_inv = v[55]; fld_cnt = v[54:52];
    sc_freq = v[51:28]; sc_phase = v[27:4];
    w = v[51:4];
    tip_win = 1'b1;
    for (int i = 1; i <= S; i++) begin
      @(negedge clk);
      chk("R2 idle before start", bus_out, idle_val());
    end
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      if (k == 0) begin
        e = {4'h0, v[3:0]};
        chk(v[56] ? "R6 R7 field nibble" : "R5 R7 field nibble", bus_out, e);
      end else begin
        e = {4'h0, w[47 - 4*(k-1) -: 4]};
        chk(mid_change ? "R8 R3 R4 nibble" : "R3 R4 nibble", bus_out, e);
      end
      if (mid_change && k == 2) begin
        sc_freq = ~sc_freq; sc_phase = ~sc_phase; fld_cnt = ~fld_cnt; v_inv = ~v_inv;
      end
      if (retrig && k == 5) tip_win = 1'b0;
      if (retrig && k == 6) tip_win = 1'b1;
    end
    @(negedge clk);
    chk("R3 back to idle", bus_out, idle_val());
    tip_win = 1'b0;
    if (retrig) begin
      for (int i = 0; i < S + 14; i++) begin
        @(negedge clk);
        chk("R11 no second packet", bus_out, idle_val());
      end
    end else begin
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, bus_out=%h expected finish", bus_out);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", bus_out, 8'hA5);
    rst_n = 1'b1;
    @(negedge clk);
    pix_in = 8'h3C;
    @(negedge clk);
    chk("R1 after reset", bus_out, 8'h3C);

    for (int n = 0; n < 4; n++) begin
      pix_in = 8'h40 + 8'(n);
      run_pkt(VEC[n], 1'b0, 1'b0);
    end

    pix_in = 8'h77;
    run_pkt(VEC[2], 1'b1, 1'b0);
    run_pkt(VEC[0], 1'b0, 1'b1);

    // R9: packet suppressed
    pkt_off = 1'b1; pix_in = 8'h9C; tip_win = 1'b1;
    for (int i = 0; i < S + 14; i++) begin
      @(negedge clk);
      chk("R9 pixels pass while disabled", bus_out, 8'h9C);
    end
    tip_win = 1'b0; pkt_off = 1'b0;
    repeat (2) @(negedge clk);

    // R10: unlocked with blanking forced
    locked = 1'b0; blank_unlk = 1'b1; pix_in = 8'hD2;
    @(negedge clk);
    chk("R10 blank while unlocked", bus_out, 8'h00);
    run_pkt(VEC[3], 1'b0, 1'b0);
    chk("R10 blank after packet", bus_out, 8'h00);
    pkt_off = 1'b1; tip_win = 1'b1;
    for (int i = 0; i < S + 14; i++) begin
      @(negedge clk);
      chk("R9 R10 disabled and blanked", bus_out, 8'h00);
    end
    tip_win = 1'b0; pkt_off = 1'b0;
    locked = 1'b1;
    @(negedge clk);
    chk("R10 no effect when locked", bus_out, 8'hD2);
    locked = 1'b0; blank_unlk = 1'b0;
    @(negedge clk);
    chk("R10 no blank without control", bus_out, 8'hD2);
    locked = 1'b1;

    summary();
  end
endmodule